// File: doc/BRIEF.md
# ChaCha Four-Block Keystream Generator

This block turns a 128-bit constant, a 256-bit key, a 96-bit nonce and a 32-bit starting counter into ChaCha keystream. The number of rounds is set per request and must be even. One accepted request yields four 64-byte blocks. Their counters are the starting counter plus 0, 1, 2 and 3, each taken modulo 2^32. The blocks leave one per 512-bit beat, in counter order. The requester may ask for the raw keystream, or for the keystream combined by XOR with its own data.

The state is built from the request inputs. All byte vectors are packed with byte i at bits [8i+7:8i], so that each 32-bit group is one little-endian word. The sixteen state words are filled as follows:

- words 0 to 3 take the constant;
- words 4 to 11 take the key;
- word 12 takes the counter, used as a plain integer;
- words 13 to 15 take the nonce.

Each output block has word w at bits [32w+31:32w], which places the least significant byte of each word first in the byte stream. One double round, a column round followed by a diagonal round, is computed per clock. After the last double round, the block's initial state is added back word by word.

While a block is being computed, the block reports that block's index on `blk_sel`. In XOR mode the requester must hold the matching 64 bytes of data on `data_in` during that time.

Top module: `chacha_quad_gen`

## Requirements
- R1: After reset, `busy`, `blk_valid`, `done` and `err` are all low.
- R2: With `rounds` = 20, the block is a standard ChaCha20 block.
  - State: words 0–3 are the constant, 4–11 the key, 12 the counter and 13–15 the nonce, with byte i of each vector at bits [8i+7:8i].
  - Rounds: each double round is a column round followed by a diagonal round.
  - Output: each word of the initial state is added back modulo 2^32, and word w is placed at `blk_out[32w+31:32w]`.
- R3: An accepted request emits exactly four blocks, with `blk_idx` = 0, 1, 2, 3 in that order. Block k uses counter `ctr_in`+k.
- R4: The per-block counter wraps modulo 2^32 and never carries into the nonce words. A request starting at 0xFFFFFFFD therefore emits, as its block 3, the block for counter 0.
- R5: When `xor_en` is 1 at start, each block is its keystream XOR `data_in` as sampled while `blk_sel` equals that block's index. When `xor_en` is 0, `data_in` has no effect.
- R6: Any nonzero even `rounds` value is honoured: `rounds`/2 double rounds are applied per block.
- R7: Timing, with H = `rounds`/2 and the start accepted at clock edge 0:
  - block k (k = 0..3) is presented with `blk_valid` high for exactly one cycle after edge (k+1)·H;
  - `busy` is high from edge 0 until edge 4·H.
- R8: A start with `rounds` equal to zero or odd is rejected. In that case `err` pulses high for one cycle after that edge, `busy` stays low and no block is emitted.
- R9: While `busy` is high, `start` and all request inputs are ignored. The running request completes with the values latched when it was accepted.
- R10: `done` pulses for exactly one cycle, together with the `blk_valid` of block 3, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled when idle |
| xor_en | input | 1 | 1: combine keystream with `data_in`; 0: raw keystream |
| rounds | input | RND_W | Round count, nonzero and even |
| cst_in | input | 128 | Constant, byte i at bits [8i+7:8i] |
| key_in | input | 256 | Key, byte i at bits [8i+7:8i] |
| nonce_in | input | 96 | Nonce, byte i at bits [8i+7:8i] |
| ctr_in | input | 32 | Starting block counter |
| data_in | input | 512 | Data for the block shown on `blk_sel` |
| blk_sel | output | BIDX_W | Index of the block being computed |
| busy | output | 1 | Request in progress |
| blk_valid | output | 1 | `blk_out` holds a finished block |
| blk_idx | output | BIDX_W | Index of the block on `blk_out` |
| blk_out | output | 512 | Output block, word w at bits [32w+31:32w] |
| done | output | 1 | One-cycle pulse with the last block |
| err | output | 1 | One-cycle pulse for a rejected round count |

## Verification
With H equal to half the round count, block k is due on `blk_out` H·(k+1) clocks after the edge that accepts the start. `done` arrives with the fourth block, and `err` arrives one clock after a rejected start. The bench changes inputs on falling edges. It counts falling edges from the start edge and requires `blk_valid` to be high at exactly those counts, comparing each block against its own model there. It checks `done` and `busy` at the count of the fourth block, and it confirms that no further block appears in the cycles that follow.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_WORDS = 16;
  localparam int unsigned BLK_W     = WORD_W * NUM_WORDS;
  localparam int unsigned CST_W     = 4 * WORD_W;
  localparam int unsigned KEY_W     = 8 * WORD_W;
  localparam int unsigned NONCE_W   = 3 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NUM_WORDS-1:0][WORD_W-1:0] state_t;
  typedef logic [BLK_W-1:0] blk_t;

  // left rotate by a constant amount
  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  // initial state: constant, key, counter, nonce (little-endian word packing)
  function automatic state_t build_state(input logic [CST_W-1:0] cst,
                                         input logic [KEY_W-1:0] key,
                                         input logic [NONCE_W-1:0] nonce,
                                         input word_t ctr);
    state_t s;
    for (int w = 0; w < 4; w++) s[w]      = cst[WORD_W*w +: WORD_W];
    for (int w = 0; w < 8; w++) s[4 + w]  = key[WORD_W*w +: WORD_W];
    s[12] = ctr;
    for (int w = 0; w < 3; w++) s[13 + w] = nonce[WORD_W*w +: WORD_W];
    return s;
  endfunction
endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
  import chacha_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1;

  // first half: rotations 16 and 12
  assign a1 = a_i + b_i;
  assign d1 = rotl(d_i ^ a1, 16);
  assign c1 = c_i + d1;
  assign b1 = rotl(b_i ^ c1, 12);

  // second half: rotations 8 and 7
  assign a_o = a1 + b1;
  assign d_o = rotl(d1 ^ a_o, 8);
  assign c_o = c1 + d_o;
  assign b_o = rotl(b1 ^ c_o, 7);
endmodule

// File: rtl/chacha_dround.sv
module chacha_dround
  import chacha_pkg::*;
(
  input  state_t s_i,
  output state_t s_o
);
  localparam int LANES = NUM_WORDS / 4;

  word_t col [NUM_WORDS];
  word_t dia [NUM_WORDS];

  for (genvar q = 0; q < LANES; q++) begin : g_lane
    // column: words q, q+4, q+8, q+12
    chacha_qr u_col (
      .a_i(s_i[q]),       .b_i(s_i[LANES + q]),
      .c_i(s_i[2*LANES + q]), .d_i(s_i[3*LANES + q]),
      .a_o(col[q]),       .b_o(col[LANES + q]),
      .c_o(col[2*LANES + q]), .d_o(col[3*LANES + q])
    );

    // diagonal: each row shifted one further than the one above
    localparam int DB = LANES     + ((q + 1) % LANES);
    localparam int DC = 2 * LANES + ((q + 2) % LANES);
    localparam int DD = 3 * LANES + ((q + 3) % LANES);
    chacha_qr u_dia (
      .a_i(col[q]),  .b_i(col[DB]), .c_i(col[DC]), .d_i(col[DD]),
      .a_o(dia[q]),  .b_o(dia[DB]), .c_o(dia[DC]), .d_o(dia[DD])
    );
  end

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) s_o[w] = dia[w];
  end
endmodule

// File: rtl/chacha_seq.sv
module chacha_seq #(
  parameter int unsigned RND_W  = 8,
  parameter int unsigned BLOCKS = 4,
  localparam int unsigned BIDX_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RND_W-1:0]  rounds,
  output logic              accept,
  output logic              fin,
  output logic [BIDX_W-1:0] blk_sel,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic              busy_q, busy_d;
  logic [RND_W-1:0]  rem_q, rem_d;
  logic [RND_W-1:0]  rnd_q, rnd_d;
  logic [BIDX_W-1:0] blk_q, blk_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              rounds_ok, last_blk;

  assign rounds_ok = (rounds != '0) && !rounds[0];
  assign accept    = start && !busy_q && rounds_ok;
  assign fin       = busy_q && (rem_q == RND_W'(2));
  assign last_blk  = (blk_q == BIDX_W'(BLOCKS - 1));

  // next state
  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    rnd_d  = rnd_q;
    blk_d  = blk_q;
    done_d = 1'b0;
    err_d  = start && !busy_q && !rounds_ok;
    if (accept) begin
      busy_d = 1'b1;
      rem_d  = rounds;
      rnd_d  = rounds;
      blk_d  = '0;
    end else if (busy_q) begin
      if (fin) begin
        if (last_blk) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          blk_d = BIDX_W'(blk_q + 1'b1);
          rem_d = rnd_q;
        end
      end else begin
        rem_d = rem_q - RND_W'(2);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      rnd_q  <= '0;
      blk_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rem_q  <= rem_d;
      rnd_q  <= rnd_d;
      blk_q  <= blk_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign blk_sel = blk_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign err     = err_q;

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: a rejection never coincides with a running request
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy_q);

  // R7: the countdown stays even and nonzero while running
  a_r7_rem_even: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (!rem_q[0] && (rem_q != '0)));

  // R9: a start while busy leaves the latched round count alone
  a_r9_rounds_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(rnd_q));
endmodule

// File: rtl/chacha_quad_gen.sv
module chacha_quad_gen
  import chacha_pkg::*;
#(
  parameter int unsigned RND_W  = 8,
  parameter int unsigned BLOCKS = 4,
  localparam int unsigned BIDX_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                xor_en,
  input  logic [RND_W-1:0]    rounds,
  input  logic [CST_W-1:0]    cst_in,
  input  logic [KEY_W-1:0]    key_in,
  input  logic [NONCE_W-1:0]  nonce_in,
  input  logic [WORD_W-1:0]   ctr_in,
  input  logic [BLK_W-1:0]    data_in,
  output logic [BIDX_W-1:0]   blk_sel,
  output logic                busy,
  output logic                blk_valid,
  output logic [BIDX_W-1:0]   blk_idx,
  output logic [BLK_W-1:0]    blk_out,
  output logic                done,
  output logic                err
);
  logic accept, fin;

  chacha_seq #(.RND_W(RND_W), .BLOCKS(BLOCKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rounds(rounds),
    .accept(accept), .fin(fin), .blk_sel(blk_sel),
    .busy(busy), .done(done), .err(err)
  );

  // request inputs latched at acceptance
  logic [CST_W-1:0]   cst_q;
  logic [KEY_W-1:0]   key_q;
  logic [NONCE_W-1:0] nonce_q;
  word_t              ctr_q;
  logic               xor_q;

  always_ff @(posedge clk) begin
    if (accept) begin
      cst_q   <= cst_in;
      key_q   <= key_in;
      nonce_q <= nonce_in;
      ctr_q   <= ctr_in;
      xor_q   <= xor_en;
    end
  end

  // working state and one double round per clock
  state_t work_q, work_d, dr_out, init_cur, init_next, ks;
  word_t  ctr_cur;
  blk_t   out_d, out_q;
  logic [BIDX_W-1:0] idx_q;
  logic   valid_q;

  chacha_dround u_dr (.s_i(work_q), .s_o(dr_out));

  assign ctr_cur   = ctr_q + word_t'(blk_sel);
  assign init_cur  = build_state(cst_q, key_q, nonce_q, ctr_cur);
  assign init_next = build_state(cst_q, key_q, nonce_q, ctr_cur + word_t'(1));

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) ks[w] = dr_out[w] + init_cur[w];
    out_d = blk_t'(ks) ^ (xor_q ? data_in : '0);
    if (accept)   work_d = build_state(cst_in, key_in, nonce_in, ctr_in);
    else if (fin) work_d = init_next;
    else          work_d = dr_out;
  end

  always_ff @(posedge clk) begin
    if (accept || busy) work_q <= work_d;
  end

  always_ff @(posedge clk) begin
    if (fin) begin
      out_q <= out_d;
      idx_q <= blk_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= fin;
  end

  assign blk_valid = valid_q;
  assign blk_idx   = idx_q;
  assign blk_out   = out_q;

  // R3: an accepted request begins at block 0
  a_r3_first_block: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && (blk_sel == '0)));

  // R10: done accompanies the last block
  a_r10_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (blk_valid && (blk_idx == BIDX_W'(BLOCKS - 1)) && !busy));

  // R9: request values stay frozen while a start arrives during busy
  a_r9_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(ctr_q) && $stable(key_q) && $stable(xor_q)));

  // R8: a rejected start emits no block
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !blk_valid);
endmodule

// File: tb/chacha_quad_gen_bench.sv
module chacha_quad_gen_bench;
  logic clk, rst_n, start, xor_en;
  logic [7:0]   rounds;
  logic [127:0] cst_in;
  logic [255:0] key_in;
  logic [95:0]  nonce_in;
  logic [31:0]  ctr_in;
  logic [511:0] data_in;
  logic [1:0]   blk_sel, blk_idx;
  logic         busy, blk_valid, done, err;
  logic [511:0] blk_out;

  logic [511:0] pt  [4];
  logic [511:0] got [4];
  int n_tests = 0;
  int n_fail  = 0;

  chacha_quad_gen u_chacha_quad_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .xor_en(xor_en), .rounds(rounds),
    .cst_in(cst_in), .key_in(key_in), .nonce_in(nonce_in), .ctr_in(ctr_in),
    .data_in(data_in), .blk_sel(blk_sel), .busy(busy), .blk_valid(blk_valid),
    .blk_idx(blk_idx), .blk_out(blk_out), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_comb data_in = pt[blk_sel];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [31:0] rl(input logic [31:0] x, input int s);
    return (x << s) | (x >> (32 - s));
  endfunction

  function automatic logic [127:0] qrf(input logic [31:0] a, input logic [31:0] b,
                                       input logic [31:0] c, input logic [31:0] d);
    a = a + b; d = rl(d ^ a, 16);
    c = c + d; b = rl(b ^ c, 12);
    a = a + b; d = rl(d ^ a, 8);
    c = c + d; b = rl(b ^ c, 7);
    return {a, b, c, d};
  endfunction

  function automatic logic [511:0] model_block(input logic [127:0] c, input logic [255:0] k,
                                               input logic [95:0] nn, input logic [31:0] ctr,
                                               input int nr);
    logic [31:0] x [16];
    logic [31:0] o [16];
    logic [511:0] r;
    for (int i = 0; i < 4; i++) x[i] = c[32*i +: 32];
    for (int i = 0; i < 8; i++) x[4+i] = k[32*i +: 32];
    x[12] = ctr;
    for (int i = 0; i < 3; i++) x[13+i] = nn[32*i +: 32];
    o = x;
    for (int dr = 0; dr < nr / 2; dr++) begin
      for (int i = 0; i < 4; i++)
        {x[i], x[4+i], x[8+i], x[12+i]} = qrf(x[i], x[4+i], x[8+i], x[12+i]);
      for (int i = 0; i < 4; i++)
        {x[i], x[4+(i+1)%4], x[8+(i+2)%4], x[12+(i+3)%4]} =
          qrf(x[i], x[4+(i+1)%4], x[8+(i+2)%4], x[12+(i+3)%4]);
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + o[i];
    return r;
  endfunction

  // ---------------- generic request runner ----------------
  task automatic run_req(input string req, input logic [31:0] c0, input int nr,
                         input bit xm, input bit poke);
    logic [511:0] exp [4];
    int  h = nr / 2;
    bit  tbad = 0, dbad = 0;
    for (int k = 0; k < 4; k++)
      exp[k] = model_block(cst_in, key_in, nonce_in, c0 + k, nr) ^ (xm ? pt[k] : 512'd0);
    @(negedge clk);
    ctr_in = c0; rounds = 8'(nr); xor_en = xm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after accepted start", 512'(busy), 512'd1);
    for (int n = 1; n <= 4 * h + 3; n++) begin
      bit ev;
      if (n > 1) @(negedge clk);
      if (poke && n == 2) begin start = 1'b1; ctr_in = c0 + 77; key_in = ~key_in; xor_en = ~xm; end
      if (poke && n == 3) start = 1'b0;
      ev = (n > 1) && ((n - 1) % h == 0) && ((n - 1) / h <= 4);
      if (blk_valid != ev) tbad = 1;
      if (blk_valid && ev) begin
        int k = (n - 1) / h - 1;
        check(blk_idx == 2'(k), "R3", "block index order", 512'(blk_idx), 512'(k));
        check(blk_out == exp[k], req, $sformatf("block %0d content", k), blk_out, exp[k]);
        got[k] = blk_out;
      end
      if (done != (n == 4 * h + 1)) dbad = 1;
      if (n == 4 * h + 1 && busy) dbad = 1;
    end
    if (poke) begin key_in = ~key_in; xor_en = xm; end
    check(!tbad, "R7", "block valid timing", 512'(tbad), 512'd0);
    check(!dbad, "R10", "done pulse and busy release", 512'(dbad), 512'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic test_reset;
    check({busy, blk_valid, done, err} == 4'b0, "R1", "outputs after reset",
          512'({busy, blk_valid, done, err}), 512'd0);
  endtask

  task automatic test_kat;
    logic [511:0] kat;
    kat = {32'h4e3c50a2, 32'he883d0cb, 32'hb94e16de, 32'hd19c12b5,
           32'ha2028bd9, 32'h05d7c214, 32'h09aa9f07, 32'h466482d2,
           32'h4e6cd4c3, 32'h9aaa2204, 32'h0368c033, 32'hc7f4d1c7,
           32'hc47120a3, 32'h1fdd0f50, 32'h15593bd1, 32'he4e7f110};
    for (int i = 0; i < 32; i++) key_in[8*i +: 8] = 8'(i);
    nonce_in = {32'h00000000, 32'h4a000000, 32'h09000000};
    run_req("R2", 32'd1, 20, 1'b0, 1'b0);
    check(got[0] == kat, "R2", "20-round known answer", got[0], kat);
  endtask

  task automatic test_wrap;
    logic [511:0] zero_blk;
    run_req("R4", 32'd0, 20, 1'b0, 1'b0);
    zero_blk = got[0];
    run_req("R4", 32'hFFFFFFFD, 20, 1'b0, 1'b0);
    check(got[3] == zero_blk, "R4", "wrapped counter block", got[3], zero_blk);
  endtask

  task automatic test_xor;
    for (int k = 0; k < 4; k++)
      for (int w = 0; w < 16; w++) pt[k][32*w +: 32] = $urandom;
    run_req("R5", 32'h12345678, 20, 1'b1, 1'b0);
    pt[2] = '0;
    run_req("R5", 32'h00000100, 8, 1'b1, 1'b0);
  endtask

  task automatic test_rounds;
    for (int k = 0; k < 4; k++) pt[k] = {16{32'hA5A5_0000 | 32'(k)}};
    key_in = {8{32'hdeadbeef}};
    run_req("R6", 32'h00000007, 8, 1'b0, 1'b0);
    run_req("R6", 32'h80000000, 2, 1'b0, 1'b0);
    run_req("R6", 32'h0000ffff, 12, 1'b0, 1'b0);
  endtask

  task automatic test_err(input int nr);
    bit bad = 0;
    @(negedge clk);
    rounds = 8'(nr); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b1 && busy == 1'b0, "R8", $sformatf("reject rounds=%0d", nr),
          512'({err, busy}), 512'b10);
    @(negedge clk);
    check(err == 1'b0, "R8", "err is one cycle", 512'(err), 512'd0);
    for (int i = 0; i < 12; i++) begin
      if (busy || blk_valid || done) bad = 1;
      @(negedge clk);
    end
    check(!bad, "R8", "no output after reject", 512'(bad), 512'd0);
  endtask

  task automatic test_busy_start;
    run_req("R9", 32'h0badf00d, 20, 1'b0, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; xor_en = 1'b0; rounds = 8'd20;
    cst_in = {32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};
    key_in = '0; nonce_in = '0; ctr_in = '0;
    for (int k = 0; k < 4; k++) pt[k] = {16{32'h5a5a5a5a ^ 32'(k)}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset;
    test_kat;
    test_wrap;
    test_rounds;
    test_xor;
    test_err(0);
    test_err(7);
    test_busy_start;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule